// File: doc/BRIEF.md
# Decode-Stage Hazard Unit

This block is the hazard logic that sits in the decode stage of a five-stage in-order pipeline. It looks at the register fields held in the fetch/decode and decode/execute pipeline registers and decides, in the same cycle, whether the pipeline must hold still for one slot or throw away the instruction just fetched. It is purely combinational. The surrounding pipeline registers use its four outputs as write enables, as a bubble select and as a squash control.

There are two reasons to hold. The first is a load in EX whose destination is a source of the instruction in decode. The second is a branch in decode whose compare needs a value that the ALU instruction in EX has not yet produced. While the pipeline holds, the PC and the fetch/decode register keep their contents. The control fields going into decode/execute are replaced by zeros, so a no-op moves down the pipe. Instructions already in EX and later stages keep moving. A jump, or a branch that the decode-stage comparator finds taken, squashes the one instruction already fetched behind it. The squash zeroes the fetch/decode instruction word, and the all-zero word decodes as a no-op with every write enable clear.

Top module: `hz_decode_unit`

## Requirements
- R1: When `ex_mem_read` is 1 and `ex_rt` equals `id_rs` or `id_rt`, the unit holds. This includes the case where the matching register is 0.
- R2: When `ex_mem_read` is 0 and `id_is_branch` is 0, no hold is raised, whatever the register fields are. A plain ALU dependency is left to forwarding.
- R3: During a hold, `pc_we` and `ifid_we` are both 0. Otherwise both are 1.
- R4: `idex_ctrl_zero` is 1 exactly in the cycles where the unit holds.
- R5: When `id_is_branch` is 1, `ex_reg_write` is 1 and `ex_dst` equals `id_rs` or `id_rt`, the unit holds.
- R6: An `ex_dst` of 0 never raises a branch-dependency hold.
- R7: A branch with `id_br_taken` = 1 and no hold raises `ifid_flush`.
- R8: `id_is_jump` = 1 with no hold raises `ifid_flush`.
- R9: Holding wins over squashing: `ifid_flush` is 0 in every cycle where the unit holds.
- R10: A branch that is not taken, with no jump present, leaves `ifid_flush` at 0.
- R11: In a running pipeline, each load-use or branch-dependency case costs exactly one bubble. An instruction squashed behind a taken branch or a jump never reaches EX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_mem_read | input | 1 | Instruction in EX reads data memory (is a load) |
| ex_reg_write | input | 1 | Instruction in EX writes a register |
| ex_rt | input | AW | rt field of the instruction in EX (load destination) |
| ex_dst | input | AW | Destination register the EX instruction will write |
| id_rs | input | AW | First source field of the instruction in decode |
| id_rt | input | AW | Second source field of the instruction in decode |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_taken | input | 1 | Decode-stage comparator result, 1 means taken |
| id_is_jump | input | 1 | Decode instruction is an unconditional jump |
| pc_we | output | 1 | PC write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_ctrl_zero | output | 1 | Selects all-zero control into decode/execute (bubble) |
| ifid_flush | output | 1 | Zeroes the instruction word loaded into fetch/decode |

## Verification
A hold and a squash can arise in the same cycle. This happens when a taken branch depends on the EX result, or when a jump's field bits happen to match a load destination. The table contains both combinations, and each must show a hold with no squash. The bench also runs a small pipeline model fed from the outputs. In that model, the same branch first holds and then squashes one cycle later. The bench checks that the total bubble and squash counts match the hand count, and that a marked squashed instruction never reaches EX.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    HZ_NONE   = 2'd0,
    HZ_LOAD   = 2'd1,
    HZ_BRANCH = 2'd2
  } hz_cause_e;

  // pick the reason for a hold; load-use is reported first when both apply
  function automatic hz_cause_e hz_pick_cause(input logic load_hit, input logic br_hit);
    if (load_hit) return HZ_LOAD;
    if (br_hit) return HZ_BRANCH;
    return HZ_NONE;
  endfunction
endpackage

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int AW = 5,
  parameter int NSRC = 2
) (
  input  logic                    ld_valid,
  input  logic [AW-1:0]           ld_dst,
  input  logic [NSRC-1:0][AW-1:0] srcs,
  output logic                    hit
);
  logic [NSRC-1:0] src_match;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign src_match[k] = (srcs[k] == ld_dst);
  end

  assign hit = ld_valid && (|src_match);
endmodule

// File: rtl/hz_branch_dep.sv
module hz_branch_dep #(
  parameter int AW = 5,
  parameter int NSRC = 2
) (
  input  logic                    is_branch,
  input  logic                    ex_writes,
  input  logic [AW-1:0]           ex_dst,
  input  logic [NSRC-1:0][AW-1:0] srcs,
  output logic                    hit
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic [NSRC-1:0] src_match;
  logic            dst_live;

  assign dst_live = ex_writes && (ex_dst != ZERO_REG);

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign src_match[k] = (srcs[k] == ex_dst);
  end

  assign hit = is_branch && dst_live && (|src_match);
endmodule

// File: rtl/hz_redirect.sv
module hz_redirect (
  input  logic hold,
  input  logic is_branch,
  input  logic br_taken,
  input  logic is_jump,
  output logic flush
);
  logic redirect_req;

  assign redirect_req = is_jump || (is_branch && br_taken);
  assign flush = redirect_req && !hold;
endmodule

// File: rtl/hz_decode_unit.sv
module hz_decode_unit #(
  parameter int AW = 5
) (
  input  logic          ex_mem_read,
  input  logic          ex_reg_write,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] ex_dst,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_is_branch,
  input  logic          id_br_taken,
  input  logic          id_is_jump,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          idex_ctrl_zero,
  output logic          ifid_flush
);
  import hz_pkg::*;

  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0] id_srcs;
  logic                    load_hit;
  logic                    br_hit;
  logic                    hold;
  hz_cause_e               cause;

  assign id_srcs = {id_rt, id_rs};

  hz_load_use #(.AW(AW), .NSRC(NSRC)) u_load (
    .ld_valid (ex_mem_read),
    .ld_dst   (ex_rt),
    .srcs     (id_srcs),
    .hit      (load_hit)
  );

  hz_branch_dep #(.AW(AW), .NSRC(NSRC)) u_brdep (
    .is_branch (id_is_branch),
    .ex_writes (ex_reg_write),
    .ex_dst    (ex_dst),
    .srcs      (id_srcs),
    .hit       (br_hit)
  );

  assign cause = hz_pick_cause(load_hit, br_hit);
  assign hold  = (cause != HZ_NONE);

  hz_redirect u_redir (
    .hold      (hold),
    .is_branch (id_is_branch),
    .br_taken  (id_br_taken),
    .is_jump   (id_is_jump),
    .flush     (ifid_flush)
  );

  assign pc_we          = !hold;
  assign ifid_we        = !hold;
  assign idex_ctrl_zero = hold;

  // port-level checks beside the combining logic
  always_comb begin
    if (ex_mem_read && (ex_rt == id_rs || ex_rt == id_rt))
      assert_load_freeze_R1: assert (!pc_we && !ifid_we);
    if (!ex_mem_read && !id_is_branch)
      assert_no_alu_hold_R2: assert (pc_we && ifid_we);
    assert_bubble_pairs_R4: assert (idex_ctrl_zero == !pc_we);
    if (!ex_mem_read && ex_dst == '0)
      assert_zero_dst_R6: assert (pc_we);
    assert_hold_beats_flush_R9: assert (!(ifid_flush && idex_ctrl_zero));
    if (id_is_jump && pc_we)
      assert_jump_squash_R8: assert (ifid_flush);
  end
endmodule

// File: tb/tb_hz_decode_unit.sv
module tb_hz_decode_unit;
  localparam int AW = 5;
  localparam int NV = 13;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          ex_mem_read, ex_reg_write, id_is_branch, id_br_taken, id_is_jump;
  logic [AW-1:0] ex_rt, ex_dst, id_rs, id_rt;
  logic          pc_we, ifid_we, idex_ctrl_zero, ifid_flush;

  hz_decode_unit #(.AW(AW)) dut (
    .ex_mem_read(ex_mem_read), .ex_reg_write(ex_reg_write), .ex_rt(ex_rt),
    .ex_dst(ex_dst), .id_rs(id_rs), .id_rt(id_rt), .id_is_branch(id_is_branch),
    .id_br_taken(id_br_taken), .id_is_jump(id_is_jump), .pc_we(pc_we),
    .ifid_we(ifid_we), .idex_ctrl_zero(idex_ctrl_zero), .ifid_flush(ifid_flush)
  );

  int n_chk = 0;
  int n_bad = 0;

  // {mr, rw, ex_rt, ex_dst, rs, rt, br, tk, jp, exp_hold, exp_flush}
  localparam logic [26:0] VEC [NV] = '{
    {1'b1,1'b1,5'd3,5'd3,5'd3,5'd4,1'b0,1'b0,1'b0,1'b1,1'b0}, // R1 rs match
    {1'b1,1'b1,5'd4,5'd4,5'd2,5'd4,1'b0,1'b0,1'b0,1'b1,1'b0}, // R1 rt match
    {1'b1,1'b1,5'd5,5'd5,5'd2,5'd4,1'b0,1'b0,1'b0,1'b0,1'b0}, // R1 no match
    {1'b0,1'b1,5'd2,5'd2,5'd2,5'd4,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2 alu dep
    {1'b0,1'b1,5'd7,5'd2,5'd2,5'd9,1'b1,1'b0,1'b0,1'b1,1'b0}, // R5 rs
    {1'b0,1'b1,5'd7,5'd9,5'd2,5'd9,1'b1,1'b1,1'b0,1'b1,1'b0}, // R9 taken+dep
    {1'b0,1'b1,5'd7,5'd0,5'd0,5'd9,1'b1,1'b1,1'b0,1'b0,1'b1}, // R6 dst 0
    {1'b0,1'b0,5'd7,5'd2,5'd2,5'd9,1'b1,1'b1,1'b0,1'b0,1'b1}, // R7 no writer
    {1'b0,1'b1,5'd7,5'd3,5'd2,5'd9,1'b1,1'b0,1'b0,1'b0,1'b0}, // R10
    {1'b0,1'b1,5'd7,5'd3,5'd2,5'd9,1'b0,1'b0,1'b1,1'b0,1'b1}, // R8 jump
    {1'b1,1'b1,5'd2,5'd2,5'd2,5'd9,1'b0,1'b0,1'b1,1'b1,1'b0}, // R9 jump+load
    {1'b0,1'b0,5'd0,5'd0,5'd0,5'd0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R3 idle
    {1'b1,1'b1,5'd0,5'd0,5'd0,5'd5,1'b0,1'b0,1'b0,1'b1,1'b0}  // R1 reg 0
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1, 2, 12: return "R1";
      3:  return "R2";
      4:  return "R5";
      5, 10: return "R9";
      6:  return "R6";
      7:  return "R7";
      8:  return "R10";
      9:  return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic drive(input logic [26:0] v);
    {ex_mem_read, ex_reg_write, ex_rt, ex_dst, id_rs, id_rt,
     id_is_branch, id_br_taken, id_is_jump} = v[26:2];
  endtask

  task automatic check_out(input string tag, input logic eh, input logic ef);
    logic [3:0] got, exp;
    got = {pc_we, ifid_we, idex_ctrl_zero, ifid_flush};
    exp = {!eh, !eh, eh, ef};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {pc_we,ifid_we,zero,flush} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic check_val(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // pipeline model: one instruction record
  typedef struct packed {
    logic          ld;
    logic          wr;
    logic [AW-1:0] dst;
    logic [AW-1:0] rs;
    logic [AW-1:0] rt;
    logic          br;
    logic          tk;
    logic          jp;
  } ins_t;

  localparam int NPROG = 7;

  function automatic ins_t prog(input int pc);
    ins_t z;
    z = '0;
    case (pc)
      0: begin z.ld = 1; z.wr = 1; z.dst = 5'd3; z.rt = 5'd3; z.rs = 5'd1; end
      1: begin z.wr = 1; z.dst = 5'd5; z.rs = 5'd3; z.rt = 5'd1; end
      2: begin z.br = 1; z.tk = 1; z.rs = 5'd5; z.rt = 5'd0; end
      3: begin z.wr = 1; z.dst = 5'd9; z.rs = 5'd1; z.rt = 5'd2; end
      4: begin z.jp = 1; end
      5: begin z.wr = 1; z.dst = 5'd9; z.rs = 5'd2; z.rt = 5'd2; end
      default: z = '0;
    endcase
    return z;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    ins_t ifid, idex;
    int pc, holds, flushes, squashed_in_ex;
    drive('0);
    @(negedge clk);
    #1 check_out("R3 idle state", 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #1 check_out(vec_tag(i), VEC[i][1], VEC[i][0]);
    end

    // directed: load-use on rt while a taken branch is in decode (R9)
    @(negedge clk);
    drive({1'b1,1'b1,5'd6,5'd6,5'd1,5'd6,1'b1,1'b1,1'b0,2'b00});
    #1 check_out("R9 load+taken", 1'b1, 1'b0);
    // directed: branch dependency through rt (R5)
    @(negedge clk);
    drive({1'b0,1'b1,5'd0,5'd8,5'd1,5'd8,1'b1,1'b0,1'b0,2'b00});
    #1 check_out("R5 rt", 1'b1, 1'b0);

    // cycle-level pipeline run (R11)
    ifid = '0; idex = '0; pc = 0; holds = 0; flushes = 0; squashed_in_ex = 0;
    for (int cyc = 0; cyc < 40 && pc < NPROG; cyc++) begin
      @(negedge clk);
      ex_mem_read  = idex.ld;  ex_reg_write = idex.wr;
      ex_rt        = idex.rt;  ex_dst       = idex.dst;
      id_rs        = ifid.rs;  id_rt        = ifid.rt;
      id_is_branch = ifid.br;  id_br_taken  = ifid.tk;
      id_is_jump   = ifid.jp;
      #1;
      if (idex_ctrl_zero) holds++;
      if (ifid_flush) flushes++;
      if (idex.wr && idex.dst == 5'd9) squashed_in_ex++;
      @(posedge clk);
      if (pc_we) begin
        idex = idex_ctrl_zero ? '0 : ifid;
        ifid = ifid_flush ? '0 : prog(pc);
        pc++;
      end else begin
        idex = '0;
      end
    end
    check_val("R11 bubbles", holds, 2);
    check_val("R11 squashes", flushes, 2);
    check_val("R11 squashed reached EX", squashed_in_ex, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule